// File: doc/BRIEF.md
# Link-Layer Transmit Priority Arbiter

This block decides which link-layer packet source owns the transmit path next. Six sources compete for it:
- flow-control initialization packets
- acknowledge/negative-acknowledge packets
- flow-control update packets
- power-management packets
- replayed packets from the retry store
- new transaction packets

Each source raises a request and ends its packet with an end-of-packet flag. The arbiter gives a one-hot grant, holds it for the whole packet, and picks the next owner at the edge where the packet ends.

The acknowledge source and the flow-control update source each carry an urgency flag. With the flag set, the source competes in a high slot near the top of the order. With the flag clear, it competes in a low slot below the packet traffic. The arbiter therefore ranks eight levels while it serves six sources. The winning level is reported beside the grant, so the path downstream can tell which slot was used.

Top module: `lltx_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, `gnt` is all zeros, `sop` is 0 and `level` is 0 until a request is seen.
- R2: A flow-control initialization request (source bit 0) wins over every other request, at level 0.
- R3: An urgent acknowledge request (source bit 1 with `ack_urgent`=1, level 1) wins over an urgent flow-control update request (source bit 2 with `fcu_urgent`=1, level 2). That in turn wins over a power-management request (source bit 3, level 3).
- R4: A power-management request wins over a replay request (source bit 4, level 4), which wins over a new-packet request (source bit 5, level 5).
- R5: A non-urgent flow-control update (level 6) loses to a new-packet request. A non-urgent acknowledge (level 7) loses to every other request.
- R6: The urgency flags are sampled only when a new owner is chosen. They move the acknowledge or flow-control update source between its high slot and its low slot, and `level` reports the slot that won.
- R7: Once a source is granted, the grant stays with it until that source asserts its bit of `eop`. A higher-priority request arriving meanwhile does not preempt it.
- R8: When the owner asserts `eop`, the next owner is chosen at that same edge, so a waiting source is granted in the very next cycle with no idle cycle.
- R9: `gnt` is one-hot or zero. It is zero when nothing is requesting at an arbitration point.
- R10: `sop` is 1 exactly in the first cycle of each grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 6 | Requests: bit 0 fc-init, 1 ack/nak, 2 fc-update, 3 power-mgmt, 4 replay, 5 new packet |
| eop | input | 6 | End-of-packet flag from each source, used only for the current owner |
| ack_urgent | input | 1 | Puts the ack/nak source in its high slot |
| fcu_urgent | input | 1 | Puts the fc-update source in its high slot |
| gnt | output | 6 | One-hot grant, same bit order as `req` |
| sop | output | 1 | First cycle of a grant |
| level | output | 3 | Priority level (0 highest, 7 lowest) of the current grant |

## Verification
The bench runs every adjacent pair of the eight levels. It also toggles the urgency flags on the same pair of sources. A design with a swapped level, or one that ignores the urgency flag, grants the wrong bit or reports the wrong level.

One test holds a multi-cycle new packet while a flow-control initialization request arrives. A design that preempts would move the grant before `eop`.

Back-to-back packets are checked for a grant in the cycle right after `eop`. A design that inserts an idle cycle shows a zero grant there. A design that leaves `sop` high on later beats is caught on the second beat.

// File: rtl/lltx_arbiter.sv
module lltx_arbiter #(
  parameter int NSRC = 6,
  parameter int NLVL = 8,
  localparam int LW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] eop,
  input  logic            ack_urgent,
  input  logic            fcu_urgent,
  output logic [NSRC-1:0] gnt,
  output logic            sop,
  output logic [LW-1:0]   level
);

  localparam int S_FCI = 0;
  localparam int S_ACK = 1;
  localparam int S_FCU = 2;
  localparam int S_PM  = 3;
  localparam int S_RPL = 4;
  localparam int S_TLP = 5;

  logic [NLVL-1:0] lvl_req;
  logic [LW-1:0]   win;
  logic [NSRC-1:0] win_gnt;
  logic            any_req;
  logic            arb_ok;

  assign lvl_req[0] = req[S_FCI];
  assign lvl_req[1] = req[S_ACK] &  ack_urgent;
  assign lvl_req[2] = req[S_FCU] &  fcu_urgent;
  assign lvl_req[3] = req[S_PM];
  assign lvl_req[4] = req[S_RPL];
  assign lvl_req[5] = req[S_TLP];
  assign lvl_req[6] = req[S_FCU] & ~fcu_urgent;
  assign lvl_req[7] = req[S_ACK] & ~ack_urgent;

  assign any_req = |lvl_req;
  assign arb_ok  = (gnt == '0) || ((gnt & eop) != '0);

  always_comb begin
    win = '0;
    for (int i = NLVL - 1; i >= 0; i--)
      if (lvl_req[i]) win = LW'(i);
  end

  always_comb begin
    win_gnt = '0;
    case (win)
      3'd0:    win_gnt[S_FCI] = 1'b1;
      3'd1:    win_gnt[S_ACK] = 1'b1;
      3'd2:    win_gnt[S_FCU] = 1'b1;
      3'd3:    win_gnt[S_PM]  = 1'b1;
      3'd4:    win_gnt[S_RPL] = 1'b1;
      3'd5:    win_gnt[S_TLP] = 1'b1;
      3'd6:    win_gnt[S_FCU] = 1'b1;
      default: win_gnt[S_ACK] = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt   <= '0;
      sop   <= 1'b0;
      level <= '0;
    end else if (arb_ok) begin
      gnt   <= any_req ? win_gnt : '0;
      sop   <= any_req;
      level <= any_req ? win : '0;
    end else begin
      sop   <= 1'b0;
    end
  end

  // R9: at most one grant
  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));

  // R7: the owner keeps the grant until it signals end of packet
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt != '0) && ((gnt & eop) == '0)) |=> (gnt == $past(gnt)));

  // R9: no request at an arbitration point leaves no grant
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_ok && (req == '0)) |=> (gnt == '0));

  // R8: a waiting request at end of packet is granted in the next cycle
  p_b2b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (((gnt & eop) != '0) && (req != '0)) |=> (gnt != '0));

  // R10: a start flag always comes with a grant
  p_sop_r10: assert property (@(posedge clk) disable iff (!rst_n) sop |-> (gnt != '0));

  // R2: the initialization source wins any free arbitration
  p_fci_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_ok && req[S_FCI]) |=> gnt[S_FCI]);

endmodule

// File: tb/lltx_arbiter_test.sv
module lltx_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] req = '0;
  logic [5:0] eop = '0;
  logic       ack_urgent = 1'b0;
  logic       fcu_urgent = 1'b0;
  logic [5:0] gnt;
  logic       sop;
  logic [2:0] level;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  lltx_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req(req), .eop(eop),
    .ack_urgent(ack_urgent), .fcu_urgent(fcu_urgent),
    .gnt(gnt), .sop(sop), .level(level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [5:0] g, input logic s, input logic [2:0] l,
                     input logic [5:0] eg, input logic es, input logic [2:0] el);
    checks++;
    if (g !== eg || s !== es || l !== el) begin
      fails++;
      $display("FAIL %s: gnt=%b sop=%b level=%0d expected gnt=%b sop=%b level=%0d",
               tag, g, s, l, eg, es, el);
    end
  endtask

  task automatic arb(input string tag, input logic [5:0] r, input logic au, input logic fu,
                     input logic [5:0] eg, input logic [2:0] el);
    @(negedge clk);
    req = r; ack_urgent = au; fcu_urgent = fu; eop = '1;
    @(negedge clk);
    chk(tag, gnt, sop, level, eg, 1'b1, el);
    req = '0;
    @(negedge clk);
    chk({tag, " release R9"}, gnt, sop, level, 6'b0, 1'b0, 3'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 in reset", gnt, sop, level, 6'b0, 1'b0, 3'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", gnt, sop, level, 6'b0, 1'b0, 3'd0);
  endtask

  task automatic t_order;
    arb("R2 fci over all", 6'b111111, 1'b1, 1'b1, 6'b000001, 3'd0);
    arb("R3 urgent ack over urgent fcu", 6'b000110, 1'b1, 1'b1, 6'b000010, 3'd1);
    arb("R3 urgent fcu over pm", 6'b001100, 1'b0, 1'b1, 6'b000100, 3'd2);
    arb("R4 pm over replay", 6'b011000, 1'b0, 1'b0, 6'b001000, 3'd3);
    arb("R4 replay over tlp", 6'b110000, 1'b0, 1'b0, 6'b010000, 3'd4);
    arb("R5 tlp over lazy fcu", 6'b100100, 1'b0, 1'b0, 6'b100000, 3'd5);
    arb("R5 lazy fcu over lazy ack", 6'b000110, 1'b0, 1'b0, 6'b000100, 3'd6);
    arb("R5 lazy ack alone", 6'b000010, 1'b0, 1'b0, 6'b000010, 3'd7);
  endtask

  task automatic t_urgency;
    arb("R6 lazy ack below tlp", 6'b100010, 1'b0, 1'b0, 6'b100000, 3'd5);
    arb("R6 urgent ack above tlp", 6'b100010, 1'b1, 1'b0, 6'b000010, 3'd1);
    arb("R6 lazy fcu below replay", 6'b010100, 1'b1, 1'b0, 6'b010000, 3'd4);
    arb("R6 urgent fcu above pm", 6'b001100, 1'b0, 1'b1, 6'b000100, 3'd2);
  endtask

  task automatic t_nopreempt;
    @(negedge clk);
    req = 6'b100000; eop = '0; ack_urgent = 0; fcu_urgent = 0;
    @(negedge clk);
    chk("R7 tlp granted", gnt, sop, level, 6'b100000, 1'b1, 3'd5);
    req = 6'b100001;
    @(negedge clk);
    chk("R7 no preempt beat 2 R10", gnt, sop, level, 6'b100000, 1'b0, 3'd5);
    @(negedge clk);
    chk("R7 no preempt beat 3", gnt, sop, level, 6'b100000, 1'b0, 3'd5);
    eop = 6'b100000; req = 6'b000001;
    @(negedge clk);
    chk("R8 fci right after eop", gnt, sop, level, 6'b000001, 1'b1, 3'd0);
    req = '0; eop = '1;
    @(negedge clk);
    chk("R9 idle after fci", gnt, sop, level, 6'b0, 1'b0, 3'd0);
  endtask

  task automatic t_backtoback;
    @(negedge clk);
    req = 6'b110000; eop = '1;
    @(negedge clk);
    chk("R8 replay first", gnt, sop, level, 6'b010000, 1'b1, 3'd4);
    req = 6'b100000;
    @(negedge clk);
    chk("R8 tlp next cycle", gnt, sop, level, 6'b100000, 1'b1, 3'd5);
    @(negedge clk);
    chk("R10 same source again", gnt, sop, level, 6'b100000, 1'b1, 3'd5);
    req = '0;
    @(negedge clk);
    chk("R9 idle at end", gnt, sop, level, 6'b0, 1'b0, 3'd0);
  endtask

  initial begin
    t_reset();
    t_order();
    t_urgency();
    t_nopreempt();
    t_backtoback();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule